// File: doc/BRIEF.md
# Load Address and Alignment Unit

This block serves the load path of a 64-bit load-store datapath. Each request carries a base register value and a signed 16-bit offset. The block adds them to form the effective address. It then checks that the address is naturally aligned for the requested access width. If the access is aligned, it takes the selected bytes out of a 64-bit memory read word and widens them to 64 bits, either by copying the sign bit or by filling with zeros.

There are two ways to use it. A zero offset gives register-indirect addressing. A base value of zero, as read from a hard-wired zero register, gives absolute addressing. All outputs are registered and appear one clock after the request strobe. A misaligned request returns no data: it raises a fault flag for that one result cycle and drives the result to zero. Caches, the register file and splitting of misaligned accesses are handled elsewhere.

Top module: `load_align_unit`

## Requirements
- R1: During and directly after synchronous reset, `res_valid`, `misalign`, `eff_addr` and `result` are all zero.
- R2: `res_valid` is high in exactly the cycle after a cycle in which `req_valid` was high.
- R3: `eff_addr` equals `base_val` plus `disp` sign-extended to 64 bits, modulo 2^64. It is registered along with the request.
- R4: The width code `size_code` is 00 for byte, 01 for halfword, 10 for word and 11 for doubleword. A byte access is never misaligned. A halfword needs address bit 0 to be zero. A word needs address bits [1:0] to be zero. A doubleword needs address bits [2:0] to be zero.
- R5: A misaligned request sets `misalign` for its one result cycle and forces `result` to zero.
- R6: Memory is little-endian. Address bits [2:0] select the lowest byte lane of the access, and lane k is `mem_rdata[8k+7:8k]`.
- R7: When `is_signed` is 1, bits of `result` above the loaded width are copies of the loaded value's most significant bit.
- R8: When `is_signed` is 0, bits of `result` above the loaded width are zero.
- R9: An aligned doubleword load returns `mem_rdata` unchanged, whatever the value of `is_signed`.
- R10: In a cycle after one without `req_valid`, `res_valid`, `misalign` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| base_val | input | 64 | Base register value |
| disp | input | 16 | Signed address offset |
| size_code | input | 2 | Access width code |
| is_signed | input | 1 | 1 = sign-extend, 0 = zero-fill |
| mem_rdata | input | 64 | Memory word holding the addressed bytes |
| res_valid | output | 1 | Result valid, one cycle after the request |
| eff_addr | output | 64 | Registered effective address |
| misalign | output | 1 | Alignment fault for this result |
| result | output | 64 | Extended load data, zero on a fault |

## Verification
Every internal state of this block sits in a single output register stage, so any wrong value shows up on the ports in the cycle right after the request. A wrong lane select or a wrong shift shows as bytes moved within `result`. A wrong sign source shows as wrong upper bits. A wrong alignment mask shows as `misalign` set at the wrong offsets, and on a fault the data is zeroed. The sweep covers every width, every lane offset and both extension modes, with data words whose byte sign bits differ, so each of these errors changes at least one compared value.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE   = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_DOUBLE = 2'b11
  } size_e;

  localparam int unsigned LANE_W = 3;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    addr     = base_val + disp_ext;
  end
endmodule

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_pkg::*;
(
  input  logic [LANE_W-1:0] lane,
  input  size_e             size,
  output logic              misaligned
);
  logic [LANE_W-1:0] low_mask;

  always_comb begin
    unique case (size)
      SZ_BYTE:   low_mask = 3'b000;
      SZ_HALF:   low_mask = 3'b001;
      SZ_WORD:   low_mask = 3'b011;
      default:   low_mask = 3'b111;
    endcase
    misaligned = |(lane & low_mask);
  end
endmodule

// File: rtl/lsu_lane_extract.sv
module lsu_lane_extract
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANE_W-1:0] lane,
  input  size_e             size,
  input  logic              is_signed,
  output logic [DATA_W-1:0] value
);
  localparam int unsigned SHW = LANE_W + 3;

  logic [DATA_W-1:0] shifted;
  logic [SHW-1:0]    shamt;
  logic              fill;

  always_comb begin
    shamt   = {lane, 3'b000};
    shifted = rdata >> shamt;
    fill    = 1'b0;
    unique case (size)
      SZ_BYTE: begin
        fill  = is_signed & shifted[7];
        value = {{(DATA_W-8){fill}}, shifted[7:0]};
      end
      SZ_HALF: begin
        fill  = is_signed & shifted[15];
        value = {{(DATA_W-16){fill}}, shifted[15:0]};
      end
      SZ_WORD: begin
        fill  = is_signed & shifted[31];
        value = {{(DATA_W-32){fill}}, shifted[31:0]};
      end
      default: value = shifted;
    endcase
  end
endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        size_code,
  input  logic              is_signed,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic [DATA_W-1:0] eff_addr,
  output logic              misalign,
  output logic [DATA_W-1:0] result
);
  size_e             size;
  logic [DATA_W-1:0] addr_c;
  logic              mis_c;
  logic [DATA_W-1:0] value_c;

  assign size = size_e'(size_code);

  lsu_addr_gen #(.ADDR_W(DATA_W), .DISP_W(DISP_W)) u_agen (
    .base_val (base_val),
    .disp     (disp),
    .addr     (addr_c)
  );

  lsu_align_check u_align (
    .lane       (addr_c[LANE_W-1:0]),
    .size       (size),
    .misaligned (mis_c)
  );

  lsu_lane_extract #(.DATA_W(DATA_W)) u_extract (
    .rdata     (mem_rdata),
    .lane      (addr_c[LANE_W-1:0]),
    .size      (size),
    .is_signed (is_signed),
    .value     (value_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      eff_addr  <= '0;
      misalign  <= 1'b0;
      result    <= '0;
    end else begin
      res_valid <= req_valid;
      eff_addr  <= req_valid ? addr_c : '0;
      misalign  <= req_valid & mis_c;
      result    <= (req_valid && !mis_c) ? value_c : '0;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_valid == $past(req_valid))); // R2

  AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (result == '0)); // R5

  AST_FAULT_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    misalign |-> res_valid); // R10

  AST_BYTE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && size_code == 2'b00)) |-> !misalign); // R4

  AST_DOUBLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && size_code == 2'b11) && !misalign)
      |-> (result == $past(mem_rdata))); // R9

  AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !is_signed && size_code == 2'b00))
      |-> (result[DATA_W-1:8] == '0)); // R8
endmodule

// File: tb/load_align_unit_bench.sv
`timescale 1ns/1ps
module load_align_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [63:0] base_val;
  logic [15:0] disp;
  logic [1:0]  size_code;
  logic        is_signed;
  logic [63:0] mem_rdata;
  logic        res_valid;
  logic [63:0] eff_addr;
  logic        misalign;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  load_align_unit u_load_align_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .base_val(base_val),
    .disp(disp), .size_code(size_code), .is_signed(is_signed),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .eff_addr(eff_addr),
    .misalign(misalign), .result(result)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] w, input logic [2:0] lane,
                                        input logic [1:0] sz, input logic sg);
    int nb;
    logic [63:0] r;
    nb = 1 << sz;
    r = 64'd0;
    for (int i = 0; i < nb; i++) r[i*8 +: 8] = w[(lane + i)*8 +: 8];
    if (sg && nb < 8 && r[nb*8-1])
      for (int b = nb*8; b < 64; b++) r[b] = 1'b1;
    return r;
  endfunction

  task automatic run_op(input logic [63:0] b, input logic [15:0] d, input logic [1:0] sz,
                        input logic sg, input logic [63:0] w);
    logic [63:0] ea, exp_r;
    logic        exp_m;
    @(negedge clk);
    req_valid = 1'b1; base_val = b; disp = d; size_code = sz; is_signed = sg; mem_rdata = w;
    ea    = b + {{48{d[15]}}, d};
    exp_m = (ea[2:0] & 3'((1 << sz) - 1)) != 3'd0;
    exp_r = exp_m ? 64'd0 : model(w, ea[2:0], sz, sg);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check("R2 valid", {63'd0, res_valid}, 64'd1);
    check("R3 addr", eff_addr, ea);
    check("R4 align", {63'd0, misalign}, {63'd0, exp_m});
    if (exp_m)             check("R5 fault result", result, exp_r);
    else if (sz == 2'b11)  check("R9 double", result, exp_r);
    else if (sg)           check("R6 R7 signed", result, exp_r);
    else                   check("R6 R8 unsigned", result, exp_r);
  endtask

  initial begin
    logic [63:0] pats [3];
    pats[0] = 64'hF1E2_D3C4_B5A6_9788;
    pats[1] = 64'h0172_6354_4536_2718;
    pats[2] = 64'h80FF_7F00_8001_7FFE;
    rst = 1'b1; req_valid = 1'b0; base_val = '0; disp = '0;
    size_code = '0; is_signed = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {63'd0, res_valid}, 64'd0);
    check("R1 reset fault", {63'd0, misalign}, 64'd0);
    check("R1 reset result", result, 64'd0);
    check("R1 reset addr", eff_addr, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 after reset result", result, 64'd0);
    check("R10 idle valid", {63'd0, res_valid}, 64'd0);
    for (int p = 0; p < 3; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++)
          for (int sg = 0; sg < 2; sg++)
            run_op(64'h0000_1000_0000_0100 + 64'(off), 16'd0, 2'(sz), sg[0], pats[p]);
    // R3: negative offsets, absolute addressing, wraparound
    run_op(64'h0000_0000_0000_2000, 16'hFFF8, 2'b11, 1'b1, pats[0]);
    run_op(64'd0, 16'h7FFE, 2'b01, 1'b1, pats[2]);
    run_op(64'hFFFF_FFFF_FFFF_FFFC, 16'h0006, 2'b01, 1'b0, pats[1]);
    run_op(64'h0000_0000_0000_0003, 16'h8001, 2'b10, 1'b1, pats[0]);
    @(negedge clk);
    @(posedge clk);
    #1;
    check("R10 idle valid", {63'd0, res_valid}, 64'd0);
    check("R10 idle fault", {63'd0, misalign}, 64'd0);
    check("R10 idle result", result, 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule